// File: doc/BRIEF.md
# Debug Single-Step Run Controller

This block decides, cycle by cycle, whether the processor core may issue its next instruction while a debugger is in control. It holds a halted state. It gives the core an issue permission and an interrupt-acceptance gate. It reacts to instruction retirement, debugger resume strobes, a decoded HALT instruction and breakpoint triggers.

A four-bit configuration selects its modes:

- **Single-step** halts after every completed instruction. Each resume strobe then allows exactly one further instruction.
- **Interrupt masking** blocks interrupt acceptance while single-stepping.
- **Unprivileged halt** lets HALT work from user level; otherwise a user-level HALT only raises a violation pulse.
- **Serialised mode** keeps one instruction in flight and inserts a fixed quiet gap after each retirement. In this mode address/data triggers stop the next issue in the same cycle, so they are reported precisely.

The core is assumed to issue one instruction in every cycle in which the issue permission is high.

Top module: `dbg_step_ctrl`

## Requirements
- R1: With the step bit set, a retire pulse makes halted_o high from the next cycle, and issue_en_o stays low while halted.
- R2: A resume strobe while halted clears halted_o in the next cycle; with the step bit set, issue_en_o is then high for exactly one cycle and stays low until the next retire halts the block again.
- R3: A resume strobe while not halted has no effect: halted_o is unchanged and, in step mode, no second issue is permitted before the retire.
- R4: If the step bit is cleared while halted, the next resume strobe restores free running with issue_en_o held high.
- R5: irq_take_o equals irq_pend_i when not halted, is low while halted, and is low whenever both the step bit and the interrupt-mask bit are one.
- R6: A HALT decode halts the block from the next cycle when the core is at supervisor level (user_mode_i = 0), or at either level when the unprivileged-halt bit is one.
- R7: A HALT decode at user level with the unprivileged-halt bit zero produces priv_err_o high for exactly the next cycle and does not halt.
- R8: A PC trigger forces issue_en_o low in the same cycle in any mode and halts the block from the next cycle.
- R9: An address/data trigger halts the block from the next cycle; in serialised mode it also forces issue_en_o low in the same cycle, in pipelined mode it does not.
- R10: In serialised mode, issue_en_o is low from an issue until the retire, and then low for exactly SERIAL_GAP cycles (default 5) after the retire cycle before it rises again.
- R11: When a halt cause and a resume strobe arrive in the same cycle while halted, the halt cause wins and halted_o stays high.
- R12: After reset, halted_o is low, issue_en_o is high (no triggers, configuration zero) and priv_err_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_step_i | input | 1 | Single-step mode enable |
| cfg_irq_mask_i | input | 1 | Block interrupt acceptance while stepping |
| cfg_user_halt_i | input | 1 | Allow HALT at user level |
| cfg_serial_i | input | 1 | Serialised (non-overlapped) execution |
| retire_i | input | 1 | One instruction completed this cycle |
| go_i | input | 1 | Debugger resume strobe |
| halt_op_i | input | 1 | HALT instruction decoded this cycle |
| user_mode_i | input | 1 | Core at user level (0 = supervisor) |
| irq_pend_i | input | 1 | Interrupt request pending |
| pc_trig_i | input | 1 | PC breakpoint on the instruction about to issue |
| ad_trig_i | input | 1 | Address/data breakpoint trigger |
| halted_o | output | 1 | Core held in debug halt |
| issue_en_o | output | 1 | Core may issue an instruction this cycle |
| irq_take_o | output | 1 | Core may accept the pending interrupt |
| priv_err_o | output | 1 | One-cycle privilege violation for HALT |

## Verification
The resume strobe and a halt cause can coincide. The case that matters is a PC trigger on the very instruction that the resume would release.

The bench provokes this by driving the strobe together with the trigger while the block is halted. It judges the result by requiring halted_o to stay high and issue_en_o to stay low in the following cycle. A second plain strobe must then release the block.

A related overlap is a resume strobe while the block is already running in step mode. The bench checks that this strobe does not re-arm a second issue before the retire.

// File: rtl/dbg_step_pkg.sv
// Package: shared configuration type and defaults for the debug run controller.
// Assumes: all consumers take the configuration as one packed struct.
package dbg_step_pkg;

    // Mode bits latched from the debug control word.
    typedef struct packed {
        logic step;       // halt after each retired instruction
        logic irq_mask;   // refuse interrupts while stepping
        logic user_halt;  // HALT legal at user level
        logic serial;     // one instruction in flight, gap after retire
    } step_cfg_t;

    // Run state of the controller.
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_t;

    localparam int unsigned DEF_SERIAL_GAP = 5;

endpackage

// File: rtl/dbg_halt_ctl.sv
// Module: dbg_halt_ctl
// Holds the run/halt state. Any halt cause in a cycle moves to HALT at the
// next edge; a resume strobe leaves HALT only when no cause is present.
// Assumes: halt_ok_i is already qualified for privilege by the caller.
module dbg_halt_ctl
    import dbg_step_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  step_cfg_t cfg_i,
    input  logic      retire_i,
    input  logic      go_i,
    input  logic      halt_ok_i,
    input  logic      pc_trig_i,
    input  logic      ad_trig_i,
    output logic      halted_o,
    output logic      go_acc_o
);

    run_state_t state_q;
    logic       cause;

    // Collect every reason to stop issuing.
    always_comb begin
        cause = (retire_i & cfg_i.step) | halt_ok_i | pc_trig_i | ad_trig_i;
    end

    assign halted_o = (state_q == ST_HALT);
    assign go_acc_o = halted_o & go_i;

    // Run/halt state register; halt causes take priority over resume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else if (cause) begin
            state_q <= ST_HALT;
        end else if (go_acc_o) begin
            state_q <= ST_RUN;
        end
    end

    AST_STEP_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && cfg_i.step) |=> halted_o); // R1
    AST_GO_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && go_i && !cause) |=> !halted_o); // R2
    AST_IDLE_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && go_i && !cause) |=> !halted_o); // R3
    AST_CAUSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && go_i && pc_trig_i) |=> halted_o); // R11

endmodule

// File: rtl/dbg_issue_gate.sv
// Module: dbg_issue_gate
// Produces the issue permission. It enforces one issue per resume in step
// mode and one-in-flight plus a quiet gap in serialised mode. PC triggers
// (always) and address/data triggers (serialised only) block issue at once.
// Assumes: the core issues exactly one instruction per cycle of issue_en_o.
module dbg_issue_gate
    import dbg_step_pkg::*;
#(
    parameter int unsigned SERIAL_GAP = DEF_SERIAL_GAP
) (
    input  logic      clk,
    input  logic      rst_n,
    input  step_cfg_t cfg_i,
    input  logic      halted_i,
    input  logic      go_acc_i,
    input  logic      retire_i,
    input  logic      pc_trig_i,
    input  logic      ad_trig_i,
    output logic      issue_en_o
);

    localparam int unsigned GW = (SERIAL_GAP < 1) ? 1 : $clog2(SERIAL_GAP + 1);
    localparam logic [GW-1:0] GAP_LOAD = GW'(SERIAL_GAP);

    logic          stepped_q;
    logic          inflight_q;
    logic [GW-1:0] gap_q;
    logic          serial_busy;

    assign serial_busy = cfg_i.serial & (inflight_q | (gap_q != '0));

    // Combine every blocking condition into the issue permission.
    always_comb begin
        issue_en_o = !halted_i
                   && !pc_trig_i
                   && !(cfg_i.serial && ad_trig_i)
                   && !(cfg_i.step && stepped_q)
                   && !serial_busy;
    end

    // Remember that the single permitted step has been used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stepped_q <= 1'b0;
        end else if (go_acc_i || !cfg_i.step) begin
            stepped_q <= 1'b0;
        end else if (issue_en_o) begin
            stepped_q <= 1'b1;
        end
    end

    // Track the single instruction in flight while serialised.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_i.serial) begin
            inflight_q <= 1'b0;
        end else if (retire_i) begin
            inflight_q <= 1'b0;
        end else if (issue_en_o) begin
            inflight_q <= 1'b1;
        end
    end

    // Count down the quiet gap that follows each serialised retire.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_i.serial) begin
            gap_q <= '0;
        end else if (retire_i) begin
            gap_q <= GAP_LOAD;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    AST_SERIAL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.serial && retire_i && SERIAL_GAP > 0) |=> !issue_en_o); // R10
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.step && issue_en_o) |=> (!issue_en_o || !cfg_i.step)); // R2

endmodule

// File: rtl/dbg_irq_priv.sv
// Module: dbg_irq_priv
// Qualifies a decoded HALT against privilege and raises a one-cycle
// violation pulse for an illegal one. It also gates interrupt acceptance
// by halt state and by step-mode masking.
// Assumes: halt_op_i is high for one cycle per decoded HALT.
module dbg_irq_priv
    import dbg_step_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  step_cfg_t cfg_i,
    input  logic      halted_i,
    input  logic      irq_pend_i,
    input  logic      halt_op_i,
    input  logic      user_mode_i,
    output logic      irq_take_o,
    output logic      halt_ok_o,
    output logic      priv_err_o
);

    logic bad_halt;
    logic priv_q;

    // Split a HALT decode into a legal stop and an illegal attempt.
    always_comb begin
        halt_ok_o = halt_op_i & (!user_mode_i | cfg_i.user_halt);
        bad_halt  = halt_op_i & user_mode_i & !cfg_i.user_halt;
    end

    // Allow interrupts only when running and not masked by stepping.
    always_comb begin
        irq_take_o = irq_pend_i & !halted_i & !(cfg_i.step & cfg_i.irq_mask);
    end

    // Register the violation so it appears as a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q <= 1'b0;
        end else begin
            priv_q <= bad_halt;
        end
    end

    assign priv_err_o = priv_q;

    AST_PRIV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_halt |=> priv_err_o); // R7
    AST_PRIV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad_halt) |=> !priv_err_o); // R7

endmodule

// File: rtl/dbg_step_ctrl.sv
// Module: dbg_step_ctrl (top)
// Debug run controller: gathers the mode bits into one configuration and
// wires the halt state, issue gate and interrupt/privilege logic together.
// Assumes: all inputs are synchronous to clk; triggers are single-cycle.
module dbg_step_ctrl
    import dbg_step_pkg::*;
#(
    parameter int unsigned SERIAL_GAP = DEF_SERIAL_GAP
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_step_i,
    input  logic cfg_irq_mask_i,
    input  logic cfg_user_halt_i,
    input  logic cfg_serial_i,
    input  logic retire_i,
    input  logic go_i,
    input  logic halt_op_i,
    input  logic user_mode_i,
    input  logic irq_pend_i,
    input  logic pc_trig_i,
    input  logic ad_trig_i,
    output logic halted_o,
    output logic issue_en_o,
    output logic irq_take_o,
    output logic priv_err_o
);

    step_cfg_t cfg;
    logic      halt_ok;
    logic      go_acc;

    // Pack the mode bits for the sub-blocks.
    always_comb begin
        cfg.step      = cfg_step_i;
        cfg.irq_mask  = cfg_irq_mask_i;
        cfg.user_halt = cfg_user_halt_i;
        cfg.serial    = cfg_serial_i;
    end

    dbg_irq_priv u_irq_priv (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg),
        .halted_i    (halted_o),
        .irq_pend_i  (irq_pend_i),
        .halt_op_i   (halt_op_i),
        .user_mode_i (user_mode_i),
        .irq_take_o  (irq_take_o),
        .halt_ok_o   (halt_ok),
        .priv_err_o  (priv_err_o)
    );

    dbg_halt_ctl u_halt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (cfg),
        .retire_i  (retire_i),
        .go_i      (go_i),
        .halt_ok_i (halt_ok),
        .pc_trig_i (pc_trig_i),
        .ad_trig_i (ad_trig_i),
        .halted_o  (halted_o),
        .go_acc_o  (go_acc)
    );

    dbg_issue_gate #(
        .SERIAL_GAP (SERIAL_GAP)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (cfg),
        .halted_i   (halted_o),
        .go_acc_i   (go_acc),
        .retire_i   (retire_i),
        .pc_trig_i  (pc_trig_i),
        .ad_trig_i  (ad_trig_i),
        .issue_en_o (issue_en_o)
    );

    AST_HALT_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !issue_en_o); // R1
    AST_HALT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !irq_take_o); // R5
    AST_PC_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        pc_trig_i |=> halted_o); // R8
    AST_AD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        ad_trig_i |=> halted_o); // R9

endmodule

// File: tb/dbg_step_ctrl_tb.sv
// Bench for dbg_step_ctrl: a per-cycle vector table, then directed tests.
module dbg_step_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] drv = '0;  // step,mask,uhe,ser,ret,go,hop,user,irq,pc,ad
    logic        halted, issue_en, irq_take, priv_err;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dbg_step_ctrl u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_step_i      (drv[10]),
        .cfg_irq_mask_i  (drv[9]),
        .cfg_user_halt_i (drv[8]),
        .cfg_serial_i    (drv[7]),
        .retire_i        (drv[6]),
        .go_i            (drv[5]),
        .halt_op_i       (drv[4]),
        .user_mode_i     (drv[3]),
        .irq_pend_i      (drv[2]),
        .pc_trig_i       (drv[1]),
        .ad_trig_i       (drv[0]),
        .halted_o        (halted),
        .issue_en_o      (issue_en),
        .irq_take_o      (irq_take),
        .priv_err_o      (priv_err)
    );

    // {cfg[3:0]}_{ret,go,hop,user,irq,pc,ad}_{halted,issue,irq_take,priv}
    localparam int NV = 30;
    localparam logic [14:0] VEC [0:NV-1] = '{
        15'b0000_0000100_0110, // R5 free run, interrupt accepted
        15'b1000_0000000_0100, // R1 step set, first issue allowed
        15'b1000_0000100_0010, // R5 stepping unmasked takes irq; step used
        15'b1000_1000000_0000, // R1 retire in step mode
        15'b1000_0000000_1000, // R1 halted
        15'b1100_0000100_1000, // R5 halted refuses irq
        15'b1000_0100000_1000, // R2 resume strobe
        15'b1000_0000000_0100, // R2 one issue
        15'b1100_0000100_0000, // R5 masked while stepping, no second issue
        15'b1000_0100000_0000, // R3 strobe while running ignored
        15'b1000_0000000_0000, // R3 still no second issue
        15'b1000_1000000_0000, // R1 retire halts again
        15'b0000_0000000_1000, // R4 step cleared while halted
        15'b0000_0100000_1000, // R4 resume
        15'b0000_0000000_0100, // R4 free running
        15'b0000_0000000_0100, // R4 still free running
        15'b0000_0011000_0100, // R7 user HALT not allowed
        15'b0000_0000000_0101, // R7 violation pulse, no halt
        15'b0000_0000000_0100, // R7 pulse ends
        15'b0010_0011000_0100, // R6 user HALT allowed
        15'b0000_0000000_1000, // R6 halted
        15'b0000_0100000_1000, // R6 resume
        15'b0000_0010000_0100, // R6 supervisor HALT
        15'b0000_0100010_1000, // R11 resume with PC trigger
        15'b0000_0000000_1000, // R11 trigger won, still halted
        15'b0000_0100000_1000, // R11 plain resume
        15'b0000_0000010_0000, // R8 PC trigger blocks issue now
        15'b0000_0100000_1000, // R8 halted, resume
        15'b0000_0000001_0100, // R9 pipelined data trigger, issue not blocked
        15'b0000_0100000_1000  // R9 halted, resume
    };
    localparam int VREQ [0:NV-1] = '{5,1,5,1,1,5,2,2,5,3,3,1,4,4,4,4,
                                     7,7,7,6,6,6,6,11,11,11,8,8,9,9};

    task automatic check(input string req, input logic [3:0] got,
                         input logic [3:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (halted,issue,irq,priv)",
                     req, got, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check outputs before the rising edge.
    task automatic cyc(input logic [10:0] v, input string req,
                       input logic [3:0] exp, input bit do_chk);
        @(negedge clk);
        drv = v;
        #1;
        if (do_chk) check(req, {halted, issue_en, irq_take, priv_err}, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        drv = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R12", {halted, issue_en, irq_take, priv_err}, 4'b0100);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][14:4], $sformatf("R%0d row %0d", VREQ[i], i),
                VEC[i][3:0], 1'b1);
        end

        // R10 serialised mode: one in flight, then a gap of five cycles.
        cyc(11'b0001_0000000, "R10 serial first issue", 4'b0100, 1'b1);
        cyc(11'b0001_0000000, "R10 in flight", 4'b0000, 1'b1);
        cyc(11'b0001_1000000, "R10 retire cycle", 4'b0000, 1'b1);
        for (int k = 0; k < 5; k++) begin
            cyc(11'b0001_0000000, $sformatf("R10 gap cycle %0d", k),
                4'b0000, 1'b1);
        end
        // R9 serialised data trigger blocks issue in the same cycle.
        cyc(11'b0001_0000001, "R9 serial data trigger", 4'b0000, 1'b1);
        cyc(11'b0001_0000000, "R9 serial halted", 4'b1000, 1'b1);
        cyc(11'b0001_0100000, "R9 resume", 4'b1000, 1'b1);
        cyc(11'b0001_0000000, "R10 issue after gap", 4'b0100, 1'b1);

        // R12 reset again from a halted state.
        cyc(11'b0000_0000010, "R8 pre-reset trigger", 4'b0000, 1'b1);
        @(negedge clk);
        drv = '0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R12 reset clears halt", {halted, issue_en, irq_take, priv_err},
              4'b0100);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule